// File: doc/BRIEF.md
# DDMTD Tag Period and Phase Error Unit

This unit sits behind a pair of digital dual-mixer time-difference samplers, one watching the recovered transceiver clock and one watching the local main oscillator. Each sampler delivers a free-running counter value (a tag) with a single-cycle strobe, and both arrive already in this unit's clock domain. From consecutive recovered-clock tags the unit derives how far the measured beat period departs from its nominal length. From the most recent tag of each source it derives a signed phase error centred on zero.

Both results are offered to a downstream loop filter with a sticky valid flag that stays up until the consumer pulses the matching acknowledge. Counter rollover is absorbed by modular arithmetic, so tags may wrap freely. Period and phase results are handled independently.

Top module: `ddmtd_tag_err`

## Requirements
- R1: After reset both valid flags are low, the period error reads 0x4000 and the phase error reads 0.
- R2: The first recovered-clock strobe after reset only records its tag; period_valid stays low.
- R3: Every later recovered-clock strobe sets period_valid on the following cycle, with period_err = 0x4000 minus (new tag minus previous tag), the difference taken modulo 2^TAG_W and the result a 32-bit two's complement value.
- R4: A tag counter rollover between two recovered-clock tags still yields the true spacing (e.g. tags 0xE000 then 0x2000 at 16 bits give a spacing of 0x4000 and an error of 0).
- R5: phase_valid rises only once both a recovered-clock strobe and a main strobe have occurred since reset or the last phase acknowledge.
- R6: phase_err is d = (main tag minus recovered tag) mod 0x4000 when d is at most 0x2000, and d minus 0x4000 otherwise; so d = 0x2000 gives +0x2000 and d = 0x2001 gives -0x1FFF.
- R7: Strobes of both sources in the same cycle capture both tags in that cycle, and phase_valid rises on the next cycle.
- R8: A period_ack pulse clears period_valid on the next cycle and leaves phase_valid unchanged.
- R9: A phase_ack pulse clears phase_valid and both arrival records, so a single later strobe of one source does not raise phase_valid again.
- R10: An acknowledge in the same cycle as a strobe that would set its flag leaves that flag set, carrying the new result.
- R11: Reset zeroes both stored tags and re-arms the first-tag rule, so the next recovered-clock strobe again raises no period_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both tag streams |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_stb | input | 1 | Recovered-clock tag strobe |
| rec_tag | input | TAG_W | Recovered-clock tag value |
| loc_stb | input | 1 | Main-oscillator tag strobe |
| loc_tag | input | TAG_W | Main-oscillator tag value |
| period_ack | input | 1 | Clears period_valid |
| phase_ack | input | 1 | Clears phase_valid and arrival records |
| period_valid | output | 1 | A period result is pending |
| period_err | output | 32 | Signed beat-period error |
| phase_valid | output | 1 | A phase result is pending |
| phase_err | output | 32 | Signed phase error |

## Verification
The bench builds the unit with TAG_W = 16 while keeping the 0x4000 beat, so the tag counter wraps after only four beats and rollover between consecutive recovered tags is reached with a handful of directed strobes. The narrow width also keeps the zero-extension of the spacing into the 32-bit error in play. Phase cases sit exactly on and one count past the half-period boundary.

// File: rtl/ddmtd_tag_err.sv
module ddmtd_tag_err #(
  parameter int TAG_W     = 32,
  parameter int BEAT_LOG2 = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_stb,
  input  logic [TAG_W-1:0] rec_tag,
  input  logic             loc_stb,
  input  logic [TAG_W-1:0] loc_tag,
  input  logic             period_ack,
  input  logic             phase_ack,
  output logic             period_valid,
  output logic [31:0]      period_err,
  output logic             phase_valid,
  output logic [31:0]      phase_err
);
  localparam int BEAT = 1 << BEAT_LOG2;
  localparam logic [BEAT_LOG2-1:0] HALF = BEAT_LOG2'(BEAT / 2);

  logic [TAG_W-1:0] rec_cur, rec_prev, loc_cur;
  logic armed, rec_seen, loc_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_cur      <= '0;
      rec_prev     <= '0;
      loc_cur      <= '0;
      armed        <= 1'b0;
      rec_seen     <= 1'b0;
      loc_seen     <= 1'b0;
      period_valid <= 1'b0;
    end else begin
      if (rec_stb) begin
        rec_cur <= rec_tag;
        armed   <= 1'b1;
        if (armed) rec_prev <= rec_cur;
      end
      if (loc_stb) loc_cur <= loc_tag;

      if (rec_stb && armed)  period_valid <= 1'b1;
      else if (period_ack)   period_valid <= 1'b0;

      rec_seen <= rec_stb | (rec_seen & ~phase_ack);
      loc_seen <= loc_stb | (loc_seen & ~phase_ack);
    end
  end

  logic [TAG_W-1:0]     span;
  logic [BEAT_LOG2-1:0] frac;

  assign span        = rec_cur - rec_prev;
  assign period_err  = 32'(BEAT) - 32'(span);
  assign frac        = loc_cur[BEAT_LOG2-1:0] - rec_cur[BEAT_LOG2-1:0];
  assign phase_err   = (frac > HALF) ? 32'(frac) - 32'(BEAT) : 32'(frac);
  assign phase_valid = rec_seen & loc_seen;
endmodule

// File: rtl/ddmtd_tag_err_chk.sv
module ddmtd_tag_err_chk #(
  parameter int BEAT_LOG2 = 14
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rec_stb,
  input logic        loc_stb,
  input logic        period_ack,
  input logic        phase_ack,
  input logic        armed,
  input logic        period_valid,
  input logic        phase_valid,
  input logic [31:0] phase_err
);
  localparam int HALF = (1 << BEAT_LOG2) / 2;

  p_first_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_stb && !armed && !period_valid) |=> !period_valid);

  p_rise_from_rec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(period_valid) |-> $past(rec_stb));

  p_phase_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_valid) |-> $past(rec_stb || loc_stb));

  p_phase_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid |-> ($signed(phase_err) <= HALF && $signed(phase_err) > -HALF));

  p_period_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (period_ack && !rec_stb) |=> !period_valid);

  p_phase_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_ack && !rec_stb && !loc_stb) |=> !phase_valid);

  p_stb_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_stb && armed) |=> period_valid);
endmodule

bind ddmtd_tag_err ddmtd_tag_err_chk #(.BEAT_LOG2(BEAT_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_stb(rec_stb), .loc_stb(loc_stb),
  .period_ack(period_ack), .phase_ack(phase_ack), .armed(armed),
  .period_valid(period_valid), .phase_valid(phase_valid), .phase_err(phase_err)
);

// File: tb/ddmtd_tag_err_bench.sv
module ddmtd_tag_err_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rec_stb = 0, loc_stb = 0, period_ack = 0, phase_ack = 0;
  logic [W-1:0] rec_tag = '0, loc_tag = '0;
  logic period_valid, phase_valid;
  logic [31:0] period_err, phase_err;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddmtd_tag_err #(.TAG_W(W), .BEAT_LOG2(14)) u_ddmtd_tag_err (
    .clk(clk), .rst_n(rst_n), .rec_stb(rec_stb), .rec_tag(rec_tag),
    .loc_stb(loc_stb), .loc_tag(loc_tag), .period_ack(period_ack),
    .phase_ack(phase_ack), .period_valid(period_valid), .period_err(period_err),
    .phase_valid(phase_valid), .phase_err(phase_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic step(input bit rs, input logic [W-1:0] rt, input bit ls,
                      input logic [W-1:0] lt, input bit pa, input bit ha);
    rec_stb = rs; rec_tag = rt; loc_stb = ls; loc_tag = lt;
    period_ack = pa; phase_ack = ha;
    @(negedge clk);
    rec_stb = 0; loc_stb = 0; period_ack = 0; phase_ack = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  function automatic int exp_phase(input int loc, input int rec);
    int d = (loc - rec) & 32'h3FFF;
    return (d > 32'h2000) ? d - 32'h4000 : d;
  endfunction

  task automatic t_reset();
    do_reset();
    chk(!period_valid, "R1 period_valid", int'(period_valid), 0);
    chk(!phase_valid,  "R1 phase_valid", int'(phase_valid), 0);
    chk(period_err == 32'h4000, "R1 period_err", period_err, 32'h4000);
    chk(phase_err == 0, "R1 phase_err", phase_err, 0);
  endtask

  task automatic t_first_and_period();
    step(1, 16'h1000, 0, 0, 0, 0);
    chk(!period_valid, "R2 first tag quiet", int'(period_valid), 0);
    chk(!phase_valid, "R5 rec only", int'(phase_valid), 0);
    step(1, 16'h5000, 0, 0, 0, 0);
    chk(period_valid, "R3 valid", int'(period_valid), 1);
    chk(period_err == 0, "R3 nominal", period_err, 0);
    step(1, 16'h9100, 0, 0, 0, 0);
    chk(period_err == -32'sh100, "R3 long beat", period_err, -256);
  endtask

  task automatic t_period_ack();
    step(0, 0, 0, 0, 1, 0);
    chk(!period_valid, "R8 cleared", int'(period_valid), 0);
    chk(!phase_valid, "R8 phase untouched", int'(phase_valid), 0);
  endtask

  task automatic t_wrap();
    step(1, 16'hE000, 0, 0, 0, 0);
    chk(period_err == -32'shF00, "R4 pre-wrap", period_err, -3840);
    step(1, 16'h2000, 0, 0, 0, 0);
    chk(period_err == 0, "R4 across rollover", period_err, 0);
    step(0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_phase();
    step(0, 0, 1, 16'h2000, 0, 0);
    chk(phase_valid, "R5 both seen", int'(phase_valid), 1);
    chk(phase_err == 0, "R6 aligned", phase_err, 0);
    chk(!period_valid, "R8 period untouched", int'(period_valid), 0);
    step(0, 0, 0, 0, 0, 1);
    chk(!phase_valid, "R9 cleared", int'(phase_valid), 0);
    step(0, 0, 1, 16'h4000, 0, 0);
    chk(!phase_valid, "R9 single source after ack", int'(phase_valid), 0);
    step(1, 16'h6000, 0, 0, 0, 0);
    chk(phase_valid, "R5 pair complete", int'(phase_valid), 1);
    chk(phase_err == 32'h2000, "R6 half boundary", phase_err, exp_phase(16'h4000, 16'h6000));
    step(0, 0, 0, 0, 1, 1);
  endtask

  task automatic t_same_cycle();
    step(1, 16'hA000, 1, 16'hC001, 0, 0);
    chk(phase_valid, "R7 joint strobe", int'(phase_valid), 1);
    chk(phase_err == -32'sh1FFF, "R6/R7 past half", phase_err, exp_phase(16'hC001, 16'hA000));
    chk(period_err == 0, "R7 period from joint", period_err, 0);
  endtask

  task automatic t_collide();
    step(1, 16'hE000, 1, 16'hE100, 1, 1);
    chk(period_valid, "R10 period kept", int'(period_valid), 1);
    chk(phase_valid, "R10 phase kept", int'(phase_valid), 1);
    chk(phase_err == 32'h100, "R10 new phase", phase_err, 32'h100);
    step(0, 0, 0, 0, 1, 1);
  endtask

  task automatic t_rearm();
    do_reset();
    chk(period_err == 32'h4000 && !period_valid && !phase_valid, "R11 reset state",
        period_err, 32'h4000);
    step(1, 16'h3000, 0, 0, 0, 0);
    chk(!period_valid, "R11 first tag quiet again", int'(period_valid), 0);
    step(1, 16'h7000, 0, 0, 0, 0);
    chk(period_valid && period_err == 0, "R11 second tag", period_err, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_first_and_period();
    t_period_ack();
    t_wrap();
    t_phase();
    t_same_cycle();
    t_collide();
    t_rearm();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule